// File: doc/BRIEF.md
# Data Access Translation Fault Checker

This block takes one data load or store at a time and decides how the access resolves. It checks alignment, works out the privilege mode that governs the access, and chooses between three routes: a physical bypass, a direct-mapped kernel window, or a page translation that uses the result of a TLB lookup the caller has already done. It returns a physical address, an outcome code and a six-bit memory-management status word that records why a fault was raised. TLB storage, statistics and cacheability handling belong to the neighbouring blocks.

A request is accepted by a small state machine with three states. IDLE waits for `req_valid` and captures the request (IDLE→EVAL). EVAL runs the combinational fault evaluation on the captured copy and registers the result (EVAL→REPLY). REPLY holds `rsp_valid` high for one cycle and then returns unconditionally (REPLY→IDLE). Requests that arrive outside IDLE are dropped. The caller therefore sees each reply two clock edges after the edge that accepts the request.

Outcome codes are OK=0, ALIGN=1, PAGE=2, ACV=3, MISS=4, PTMISS=5 and MCHK=6. The status bits are: bit0 write, bit1 bad virtual address, bit2 access violation, bit3 TLB miss, bit4 fault-on-read, bit5 fault-on-write. Modes are encoded as kernel=0, executive=1, supervisor=2 and user=3. Each enable mask has one bit per mode, and the mode value is the bit index.

Top module: `xlat_data_check`

## Requirements
- R1: A request is accepted only in IDLE. `rsp_valid` rises two edges after the accepting edge and lasts exactly one cycle. A request presented while a reply is still being formed is ignored. While `rsp_valid` is low, the outcome, status and address outputs are all zero.
- R2: Misalignment has the highest priority. When `req_va & (req_size-1)` is non-zero, the outcome is ALIGN(1) and the status contains only bit0, which is set for stores. This holds even when the address is otherwise invalid.
- R3: When `req_pc_lsb` is 1, the mode used for the enable checks is `alt_mode` if `req_altmode` is set and kernel otherwise. When `req_pc_lsb` is 0, that mode is `cur_mode`.
- R4: With `req_phys` set, translation and validity checks are skipped and the physical address equals the virtual address.
- R5: A virtual address whose bits 63:47 are not all equal gives PAGE(2) with status bits 1 and 2, plus bit0 for stores.
- R6: VA bits 47:41 equal to 7'h7E select the kernel window. The window is legal only when `cur_mode` is kernel, whatever the override. The address is then VA[43:0] with bits 43:40 all copied from VA bit 40. Otherwise the outcome is ACV(3) with status bit2, plus bit0 for stores.
- R7: A TLB miss gives PTMISS(5) when `req_ptefetch` is set and MISS(4) otherwise. Both carry status bit3, plus bit0 for stores.
- R8: On a store hit, a clear write-enable bit for the effective mode gives ACV(3) with status bits 0 and 2, plus bit5 if fault-on-write is set. With the enable bit set, fault-on-write alone gives PAGE(2) with status bits 0 and 5.
- R9: On a load hit, a clear read-enable bit for the effective mode gives ACV(3) with status bit2, plus bit4 if fault-on-read is set. With the enable bit set, fault-on-read alone gives PAGE(2) with status bit4.
- R10: A resulting address with any bit set at or above the implemented width (bit 44) gives MCHK(6) with zero status, and the offending address is reported.
- R11: A successful translated access returns `{ppn, VA[12:0]}` with outcome OK(0) and zero status.
- R12: Every fault outcome from ALIGN to PTMISS reports a zero physical address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken in IDLE |
| req_va | input | 64 | Virtual address |
| req_size | input | 4 | Access size in bytes (1, 2, 4 or 8) |
| req_write | input | 1 | 1 for a store |
| req_phys | input | 1 | Bypass translation |
| req_altmode | input | 1 | Use the alternate mode under privileged PC |
| req_ptefetch | input | 1 | Access is a page-table-entry fetch |
| req_pc_lsb | input | 1 | Bit 0 of the PC; 1 marks privileged code |
| cur_mode | input | 2 | Current mode register field |
| alt_mode | input | 2 | Alternate mode register field |
| tlb_hit | input | 1 | TLB lookup matched |
| tlb_ppn | input | 32 | Physical page number from the lookup |
| tlb_rd_en | input | 4 | Read enable per mode |
| tlb_wr_en | input | 4 | Write enable per mode |
| tlb_fonr | input | 1 | Fault-on-read flag |
| tlb_fonw | input | 1 | Fault-on-write flag |
| rsp_valid | output | 1 | Reply strobe |
| rsp_outcome | output | 3 | Outcome code |
| rsp_status | output | 6 | Memory-management status bits |
| rsp_pa | output | 64 | Physical address |

## Verification
The bench builds the block with its default parameters: 64-bit addresses, a 48-bit significant virtual range, 13-bit page offset, 32-bit page numbers and a 44-bit implemented physical range. Because the page number plus offset spans 45 bits, the machine check can be reached through the translated path as well as through the physical bypass. The 48-bit virtual range lets one address pass the alignment check but fail the validity check. The kernel window's sign-copy of bit 40 is exercised with that bit clear and with it set.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        MD_KERNEL = 2'd0,
        MD_EXEC   = 2'd1,
        MD_SUPER  = 2'd2,
        MD_USER   = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        OUT_OK     = 3'd0,
        OUT_ALIGN  = 3'd1,
        OUT_PAGE   = 3'd2,
        OUT_ACV    = 3'd3,
        OUT_MISS   = 3'd4,
        OUT_PTMISS = 3'd5,
        OUT_MCHK   = 3'd6
    } outc_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_EVAL  = 2'd1,
        S_REPLY = 2'd2
    } fsm_e;

    localparam int STAT_W   = 6;
    localparam int SB_WR    = 0;
    localparam int SB_BADVA = 1;
    localparam int SB_ACV   = 2;
    localparam int SB_MISS  = 3;
    localparam int SB_FONR  = 4;
    localparam int SB_FONW  = 5;

endpackage

// File: rtl/xlat_mode_sel.sv
module xlat_mode_sel
    import xlat_pkg::*;
(
    input  logic  pc_lsb,
    input  logic  alt_req,
    input  mode_e cur_mode,
    input  mode_e alt_mode,
    output mode_e eff_mode
);
    always_comb begin
        if (pc_lsb)
            eff_mode = alt_req ? alt_mode : MD_KERNEL;
        else
            eff_mode = cur_mode;
    end
endmodule

// File: rtl/xlat_fault_eval.sv
module xlat_fault_eval
    import xlat_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int VA_SIG_W  = 48,
    parameter int SIZE_W    = 4,
    parameter int PAGE_BITS = 13,
    parameter int PPN_W     = 32,
    parameter int PA_IMPL_W = 44,
    parameter int SP_HI     = 47,
    parameter int SP_LO     = 41,
    parameter logic [SP_HI-SP_LO:0] SP_TAG = 7'h7E,
    parameter int SP_EXT    = 40
) (
    input  logic [VA_W-1:0]   va,
    input  logic [SIZE_W-1:0] sz,
    input  logic              wr,
    input  logic              phys,
    input  logic              pte,
    input  mode_e             cur_mode,
    input  mode_e             eff_mode,
    input  logic              hit,
    input  logic [PPN_W-1:0]  ppn,
    input  logic [3:0]        rd_en,
    input  logic [3:0]        wr_en,
    input  logic              fonr,
    input  logic              fonw,
    output outc_e             outc,
    output logic [STAT_W-1:0] status,
    output logic [VA_W-1:0]   pa
);
    localparam int TPA_W = PPN_W + PAGE_BITS;

    logic [SIZE_W-1:0] sz_m1;
    logic              mis_al;
    logic              va_ok;
    logic              in_sp;
    logic [VA_W-1:0]   sp_pa;
    logic [VA_W-1:0]   tl_pa;
    logic              perm_ok;

    always_comb begin
        sz_m1  = sz - 1'b1;
        mis_al = |(va[SIZE_W-1:0] & sz_m1);
        va_ok  = (&va[VA_W-1:VA_SIG_W-1]) | ~(|va[VA_W-1:VA_SIG_W-1]);
        in_sp  = (va[SP_HI:SP_LO] == SP_TAG);

        sp_pa = '0;
        sp_pa[PA_IMPL_W-1:0] = va[PA_IMPL_W-1:0];
        sp_pa[PA_IMPL_W-1:SP_EXT] = {(PA_IMPL_W-SP_EXT){va[SP_EXT]}};

        tl_pa = '0;
        tl_pa[TPA_W-1:0] = {ppn, va[PAGE_BITS-1:0]};

        outc    = OUT_OK;
        status  = '0;
        pa      = '0;
        perm_ok = 1'b0;

        if (mis_al) begin
            outc = OUT_ALIGN;
            status[SB_WR] = wr;
        end else if (phys) begin
            pa = va;
        end else if (!va_ok) begin
            outc = OUT_PAGE;
            status[SB_WR]    = wr;
            status[SB_BADVA] = 1'b1;
            status[SB_ACV]   = 1'b1;
        end else if (in_sp) begin
            if (cur_mode != MD_KERNEL) begin
                outc = OUT_ACV;
                status[SB_WR]  = wr;
                status[SB_ACV] = 1'b1;
            end else begin
                pa = sp_pa;
            end
        end else if (!hit) begin
            outc = pte ? OUT_PTMISS : OUT_MISS;
            status[SB_WR]   = wr;
            status[SB_MISS] = 1'b1;
        end else if (wr) begin
            if (!wr_en[eff_mode]) begin
                outc = OUT_ACV;
                status[SB_WR]   = 1'b1;
                status[SB_ACV]  = 1'b1;
                status[SB_FONW] = fonw;
            end else if (fonw) begin
                outc = OUT_PAGE;
                status[SB_WR]   = 1'b1;
                status[SB_FONW] = 1'b1;
            end else begin
                perm_ok = 1'b1;
            end
        end else begin
            if (!rd_en[eff_mode]) begin
                outc = OUT_ACV;
                status[SB_ACV]  = 1'b1;
                status[SB_FONR] = fonr;
            end else if (fonr) begin
                outc = OUT_PAGE;
                status[SB_FONR] = 1'b1;
            end else begin
                perm_ok = 1'b1;
            end
        end

        if (perm_ok)
            pa = tl_pa;

        if (outc == OUT_OK && (|pa[VA_W-1:PA_IMPL_W]))
            outc = OUT_MCHK;
    end
endmodule

// File: rtl/xlat_data_check.sv
module xlat_data_check
    import xlat_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int VA_SIG_W  = 48,
    parameter int SIZE_W    = 4,
    parameter int PAGE_BITS = 13,
    parameter int PPN_W     = 32,
    parameter int PA_IMPL_W = 44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic [SIZE_W-1:0] req_size,
    input  logic              req_write,
    input  logic              req_phys,
    input  logic              req_altmode,
    input  logic              req_ptefetch,
    input  logic              req_pc_lsb,
    input  logic [1:0]        cur_mode,
    input  logic [1:0]        alt_mode,
    input  logic              tlb_hit,
    input  logic [PPN_W-1:0]  tlb_ppn,
    input  logic [3:0]        tlb_rd_en,
    input  logic [3:0]        tlb_wr_en,
    input  logic              tlb_fonr,
    input  logic              tlb_fonw,
    output logic              rsp_valid,
    output logic [2:0]        rsp_outcome,
    output logic [STAT_W-1:0] rsp_status,
    output logic [VA_W-1:0]   rsp_pa
);
    fsm_e state, state_nxt;

    logic [VA_W-1:0]   q_va;
    logic [SIZE_W-1:0] q_sz;
    logic              q_wr, q_phys, q_alt, q_pte, q_pc;
    mode_e             q_cur, q_altm;
    logic              q_hit;
    logic [PPN_W-1:0]  q_ppn;
    logic [3:0]        q_re, q_we;
    logic              q_fonr, q_fonw;

    mode_e             eff_mode;
    outc_e             ev_outc;
    logic [STAT_W-1:0] ev_status;
    logic [VA_W-1:0]   ev_pa;

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:  state_nxt = req_valid ? S_EVAL : S_IDLE;
            S_EVAL:  state_nxt = S_REPLY;
            S_REPLY: state_nxt = S_IDLE;
            default: state_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_va <= '0; q_sz <= '0; q_wr <= 1'b0; q_phys <= 1'b0;
            q_alt <= 1'b0; q_pte <= 1'b0; q_pc <= 1'b0;
            q_cur <= MD_KERNEL; q_altm <= MD_KERNEL; q_hit <= 1'b0;
            q_ppn <= '0; q_re <= '0; q_we <= '0;
            q_fonr <= 1'b0; q_fonw <= 1'b0;
        end else if (state == S_IDLE && req_valid) begin
            q_va <= req_va; q_sz <= req_size; q_wr <= req_write;
            q_phys <= req_phys; q_alt <= req_altmode; q_pte <= req_ptefetch;
            q_pc <= req_pc_lsb; q_cur <= mode_e'(cur_mode);
            q_altm <= mode_e'(alt_mode); q_hit <= tlb_hit; q_ppn <= tlb_ppn;
            q_re <= tlb_rd_en; q_we <= tlb_wr_en;
            q_fonr <= tlb_fonr; q_fonw <= tlb_fonw;
        end
    end

    xlat_mode_sel u_mode (
        .pc_lsb   (q_pc),
        .alt_req  (q_alt),
        .cur_mode (q_cur),
        .alt_mode (q_altm),
        .eff_mode (eff_mode)
    );

    xlat_fault_eval #(
        .VA_W      (VA_W),
        .VA_SIG_W  (VA_SIG_W),
        .SIZE_W    (SIZE_W),
        .PAGE_BITS (PAGE_BITS),
        .PPN_W     (PPN_W),
        .PA_IMPL_W (PA_IMPL_W)
    ) u_eval (
        .va       (q_va),
        .sz       (q_sz),
        .wr       (q_wr),
        .phys     (q_phys),
        .pte      (q_pte),
        .cur_mode (q_cur),
        .eff_mode (eff_mode),
        .hit      (q_hit),
        .ppn      (q_ppn),
        .rd_en    (q_re),
        .wr_en    (q_we),
        .fonr     (q_fonr),
        .fonw     (q_fonw),
        .outc     (ev_outc),
        .status   (ev_status),
        .pa       (ev_pa)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_outcome <= '0;
            rsp_status  <= '0;
            rsp_pa      <= '0;
        end else if (state == S_EVAL) begin
            rsp_valid   <= 1'b1;
            rsp_outcome <= ev_outc;
            rsp_status  <= ev_status;
            rsp_pa      <= ev_pa;
        end else begin
            rsp_valid   <= 1'b0;
            rsp_outcome <= '0;
            rsp_status  <= '0;
            rsp_pa      <= '0;
        end
    end
endmodule

// File: rtl/xlat_data_check_sva.sv
module xlat_data_check_sva
    import xlat_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int PA_IMPL_W = 44
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              rsp_valid,
    input logic [2:0]        rsp_outcome,
    input logic [STAT_W-1:0] rsp_status,
    input logic [VA_W-1:0]   rsp_pa
);
    AST_REPLY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R1
    AST_REPLY_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid, 2)); // R1
    AST_QUIET_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_outcome == 3'd0 && rsp_status == '0 && rsp_pa == '0)); // R1
    AST_ALIGN_WRBIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_outcome == OUT_ALIGN) |-> rsp_status[SB_WR] == $past(req_write, 2)); // R2
    AST_ALIGN_ONLY_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_outcome == OUT_ALIGN) |-> rsp_status[STAT_W-1:1] == '0); // R2
    AST_MISS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_outcome == OUT_MISS || rsp_outcome == OUT_PTMISS))
        |-> (rsp_status[SB_MISS] && !rsp_status[SB_ACV] && !rsp_status[SB_BADVA]
             && !rsp_status[SB_FONR] && !rsp_status[SB_FONW])); // R7
    AST_MCHK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_outcome == OUT_MCHK)
        |-> ((|rsp_pa[VA_W-1:PA_IMPL_W]) && rsp_status == '0)); // R10
    AST_OK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_outcome == OUT_OK) |-> rsp_pa[VA_W-1:PA_IMPL_W] == '0); // R10
    AST_OK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_outcome == OUT_OK) |-> rsp_status == '0); // R11
    AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_outcome != OUT_OK && rsp_outcome != OUT_MCHK) |-> rsp_pa == '0); // R12
    AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_outcome <= 3'd6); // R1
endmodule

bind xlat_data_check xlat_data_check_sva #(
    .VA_W      (VA_W),
    .PA_IMPL_W (PA_IMPL_W)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .rsp_valid   (rsp_valid),
    .rsp_outcome (rsp_outcome),
    .rsp_status  (rsp_status),
    .rsp_pa      (rsp_pa)
);

// File: tb/tb_xlat_data_check.sv
module tb_xlat_data_check;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 22;

    typedef struct packed {
        logic [3:0]  rq;
        logic [63:0] va;
        logic [3:0]  sz;
        logic        wr, phys, altf, ptef, pc0;
        logic [1:0]  cur, altm;
        logic        hit;
        logic [31:0] ppn;
        logic [3:0]  re, we;
        logic        fonr, fonw;
        logic [2:0]  eo;
        logic [63:0] epa;
        logic [5:0]  est;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        // R11 translated load, user mode allowed
        '{4'd11, 64'h0000_0000_0002_4468, 4'd8, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd3,2'd0, 1'b1, 32'h123, 4'b1000,4'b0000, 1'b0,1'b0, 3'd0, 64'h0000_0000_0024_6468, 6'h00},
        // R2 misaligned load
        '{4'd2, 64'h0000_0000_0000_0003, 4'd4, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b1, 32'h1, 4'b1111,4'b1111, 1'b0,1'b0, 3'd1, 64'h0, 6'h00},
        // R2 misaligned store
        '{4'd2, 64'h0000_0000_0000_0001, 4'd2, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b1, 32'h1, 4'b1111,4'b1111, 1'b0,1'b0, 3'd1, 64'h0, 6'h01},
        // R4 physical bypass
        '{4'd4, 64'h0000_0ABC_DEF0_0000, 4'd1, 1'b0,1'b1,1'b0,1'b0,1'b0, 2'd3,2'd0, 1'b0, 32'h0, 4'b0000,4'b0000, 1'b0,1'b0, 3'd0, 64'h0000_0ABC_DEF0_0000, 6'h00},
        // R10 physical beyond implemented range
        '{4'd10, 64'h0000_1000_0000_0000, 4'd8, 1'b0,1'b1,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0, 32'h0, 4'b0000,4'b0000, 1'b0,1'b0, 3'd6, 64'h0000_1000_0000_0000, 6'h00},
        // R5 invalid VA store
        '{4'd5, 64'h0001_0000_0000_0000, 4'd8, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b1, 32'h1, 4'b1111,4'b1111, 1'b0,1'b0, 3'd2, 64'h0, 6'h07},
        // R6 kernel window, bit40 clear
        '{4'd6, 64'hFFFF_FC00_1234_5670, 4'd8, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0, 32'h0, 4'b0000,4'b0000, 1'b0,1'b0, 3'd0, 64'h0000_0000_1234_5670, 6'h00},
        // R6 kernel window, bit40 set
        '{4'd6, 64'hFFFF_FD00_0000_2000, 4'd8, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0, 32'h0, 4'b0000,4'b0000, 1'b0,1'b0, 3'd0, 64'h0000_0F00_0000_2000, 6'h00},
        // R6 kernel window from user mode
        '{4'd6, 64'hFFFF_FC00_1234_5670, 4'd8, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd3,2'd0, 1'b0, 32'h0, 4'b0000,4'b0000, 1'b0,1'b0, 3'd3, 64'h0, 6'h04},
        // R6 override does not open the window: privileged PC, current user, store
        '{4'd6, 64'hFFFF_FC00_1234_5670, 4'd8, 1'b1,1'b0,1'b0,1'b0,1'b1, 2'd3,2'd0, 1'b0, 32'h0, 4'b0000,4'b0000, 1'b0,1'b0, 3'd3, 64'h0, 6'h05},
        // R7 normal miss, load
        '{4'd7, 64'h0000_0000_0000_2000, 4'd8, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0, 32'h0, 4'b1111,4'b1111, 1'b0,1'b0, 3'd4, 64'h0, 6'h08},
        // R7 page-table miss, store
        '{4'd7, 64'h0000_0000_0000_2000, 4'd8, 1'b1,1'b0,1'b0,1'b1,1'b0, 2'd0,2'd0, 1'b0, 32'h0, 4'b1111,4'b1111, 1'b0,1'b0, 3'd5, 64'h0, 6'h09},
        // R8 store, write disabled in supervisor, fault-on-write set
        '{4'd8, 64'h0000_0000_0000_6000, 4'd8, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'd2,2'd0, 1'b1, 32'h9, 4'b1111,4'b0001, 1'b0,1'b1, 3'd3, 64'h0, 6'h25},
        // R8 store allowed, fault-on-write alone
        '{4'd8, 64'h0000_0000_0000_6000, 4'd8, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'd2,2'd0, 1'b1, 32'h9, 4'b1111,4'b0100, 1'b0,1'b1, 3'd2, 64'h0, 6'h21},
        // R9 load, read disabled in kernel, fault-on-read set
        '{4'd9, 64'h0000_0000_0000_6000, 4'd8, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b1, 32'h9, 4'b0010,4'b1111, 1'b1,1'b0, 3'd3, 64'h0, 6'h14},
        // R9 load allowed, fault-on-read alone
        '{4'd9, 64'h0000_0000_0000_6000, 4'd8, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b1, 32'h9, 4'b0001,4'b1111, 1'b1,1'b0, 3'd2, 64'h0, 6'h10},
        // R3 privileged PC with alternate flag: alternate user mode governs
        '{4'd3, 64'h0000_0000_0000_4000, 4'd8, 1'b0,1'b0,1'b1,1'b0,1'b1, 2'd0,2'd3, 1'b1, 32'h7, 4'b1000,4'b0000, 1'b0,1'b0, 3'd0, 64'h0000_0000_0000_E000, 6'h00},
        // R3 privileged PC without alternate flag: kernel governs
        '{4'd3, 64'h0000_0000_0000_4010, 4'd8, 1'b0,1'b0,1'b0,1'b0,1'b1, 2'd3,2'd0, 1'b1, 32'h7, 4'b0001,4'b0000, 1'b0,1'b0, 3'd0, 64'h0000_0000_0000_E010, 6'h00},
        // R3 alternate executive mode lacks read enable
        '{4'd3, 64'h0000_0000_0000_4000, 4'd8, 1'b0,1'b0,1'b1,1'b0,1'b1, 2'd0,2'd1, 1'b1, 32'h7, 4'b0001,4'b0000, 1'b0,1'b0, 3'd3, 64'h0, 6'h04},
        // R10 translated address beyond implemented range
        '{4'd10, 64'h0000_0000_0000_6000, 4'd8, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b1, 32'h8000_0000, 4'b0001,4'b0000, 1'b0,1'b0, 3'd6, 64'h0000_1000_0000_0000, 6'h00},
        // R11 translated store, executive mode allowed
        '{4'd11, 64'h0000_0000_0000_3FF8, 4'd8, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'd1,2'd0, 1'b1, 32'h55, 4'b0000,4'b0010, 1'b0,1'b0, 3'd0, 64'h0000_0000_000A_BFF8, 6'h00},
        // R2 alignment wins over invalid VA
        '{4'd2, 64'h0001_0000_0000_0001, 4'd2, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0, 32'h0, 4'b0000,4'b0000, 1'b0,1'b0, 3'd1, 64'h0, 6'h01}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_va = '0;
    logic [3:0]  req_size = 4'd1;
    logic        req_write = 1'b0, req_phys = 1'b0, req_altmode = 1'b0;
    logic        req_ptefetch = 1'b0, req_pc_lsb = 1'b0;
    logic [1:0]  cur_mode = 2'd0, alt_mode = 2'd0;
    logic        tlb_hit = 1'b0;
    logic [31:0] tlb_ppn = '0;
    logic [3:0]  tlb_rd_en = '0, tlb_wr_en = '0;
    logic        tlb_fonr = 1'b0, tlb_fonw = 1'b0;
    logic        rsp_valid;
    logic [2:0]  rsp_outcome;
    logic [5:0]  rsp_status;
    logic [63:0] rsp_pa;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_data_check dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_size(req_size), .req_write(req_write), .req_phys(req_phys),
        .req_altmode(req_altmode), .req_ptefetch(req_ptefetch),
        .req_pc_lsb(req_pc_lsb), .cur_mode(cur_mode), .alt_mode(alt_mode),
        .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn), .tlb_rd_en(tlb_rd_en),
        .tlb_wr_en(tlb_wr_en), .tlb_fonr(tlb_fonr), .tlb_fonw(tlb_fonw),
        .rsp_valid(rsp_valid), .rsp_outcome(rsp_outcome),
        .rsp_status(rsp_status), .rsp_pa(rsp_pa)
    );

    task automatic chk(input string rq, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, got, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        req_va = v.va; req_size = v.sz; req_write = v.wr; req_phys = v.phys;
        req_altmode = v.altf; req_ptefetch = v.ptef; req_pc_lsb = v.pc0;
        cur_mode = v.cur; alt_mode = v.altm; tlb_hit = v.hit; tlb_ppn = v.ppn;
        tlb_rd_en = v.re; tlb_wr_en = v.we; tlb_fonr = v.fonr; tlb_fonw = v.fonw;
    endtask

    task automatic run_vec(input vec_t v);
        string rq;
        rq = $sformatf("R%0d", v.rq);
        drive(v);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(rq, "rsp_valid", {63'd0, rsp_valid}, 64'd1);
        chk(rq, "outcome", {61'd0, rsp_outcome}, {61'd0, v.eo});
        chk(rq, "status", {58'd0, rsp_status}, {58'd0, v.est});
        chk(rq, "pa", rsp_pa, v.epa);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // reset state, R1
        chk("R1", "reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
        chk("R1", "reset outcome", {61'd0, rsp_outcome}, 64'd0);
        chk("R1", "reset pa", rsp_pa, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++)
            run_vec(VECS[i]);

        // R1: second request while the first is being evaluated is dropped
        drive(VECS[0]);
        req_valid = 1'b1;
        @(negedge clk);
        drive(VECS[1]);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1", "busy reply valid", {63'd0, rsp_valid}, 64'd1);
        chk("R1", "busy reply outcome", {61'd0, rsp_outcome}, {61'd0, VECS[0].eo});
        chk("R1", "busy reply pa", rsp_pa, VECS[0].epa);
        @(negedge clk);
        chk("R1", "pulse ends", {63'd0, rsp_valid}, 64'd0);
        chk("R1", "idle status zero", {58'd0, rsp_status}, 64'd0);
        @(negedge clk);
        chk("R1", "no reply for dropped request", {63'd0, rsp_valid}, 64'd0);
        @(negedge clk);
        chk("R1", "still quiet", {63'd0, rsp_valid}, 64'd0);

        // R1: reset mid-flight clears the reply
        drive(VECS[0]);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset aborts reply", {63'd0, rsp_valid}, 64'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule